// File: doc/BRIEF.md
# Optical Black Clamp Loop Controller

This block is the digital half of a black-level servo for an image sensor front end. Every clock it receives one 12-bit converter sample, a pixel-valid qualifier and a window strobe that is high over the shielded dark pixels at the start of a line. Inside the window it measures how far each dark sample sits from a programmable black-level target and sums those errors. When the window closes, it turns the sum into a mean error, shrinks it by a programmable right shift and adds it to an 8-bit correction word. That word drives an offset DAC in front of the converter, so the loop pulls the dark level towards the target over successive lines.

A small register bank holds the target, a loop-off bit with the filter shift, and a line divider. The divider lets the correction move only on every (D+1)-th window instead of every line. With the loop switched off, the target register drives the DAC directly as a fixed offset. The correction held by the loop stays as it was and is used again when the loop is switched back on. The DAC, the amplifier, the converter and the serial port that writes the registers are outside the block and appear only as ports.

Top module: `obclamp_servo`

## Requirements
- R1: A synchronous reset, active high, sets the correction to 128, the target register to 0x40, the loop to on, the shift to 0 and the divider to 0, and clears the sample sum, the sample count and the line counter. After reset `corr_o` reads 128.
- R2: The error of one sample is (target << 2) − sample, a signed value. It is summed only in cycles where `window_i` and `pix_en_i` are both high. The first cycle of a window restarts the sum and the count.
- R3: The window ends in the first cycle in which `window_i` is low after a cycle in which it was high. In that cycle the correction becomes correction + ((sum / count, truncated toward zero) >>> shift). The shift is op-register bits [2:0]. The new value is on `corr_o` after that clock edge.
- R4: The correction saturates at 0 and at 255 and never wraps.
- R5: The correction changes only at a window end, apart from reset.
- R6: A window in which no sample was taken (count 0) leaves the correction unchanged.
- R7: With divider value D, only every (D+1)-th window end updates the correction. The other window ends discard their sum, and the line counter restarts at reset.
- R8: When op-register bit 3 is 1, the loop is off. `corr_o` then equals the target register, and window ends change neither the held correction nor the line counter. Clearing the bit brings the held correction back to `corr_o`.
- R9: A write with `cfg_we_i` high goes to the target register when `cfg_sel_i` is 0, to the op register when it is 1 and to the divider when it is 2. A write with `cfg_sel_i` equal to 3 changes nothing. A write takes effect at the next clock edge.
- R10: The sample count saturates at 1023. Samples after the 1023rd in one window are not summed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 12 | Converter output sample |
| pix_en_i | input | 1 | Sample valid in this cycle |
| window_i | input | 1 | Dark-pixel clamp window strobe |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 target, 1 op, 2 divider |
| cfg_wdata_i | input | 8 | Register write data |
| corr_o | output | 8 | Correction word to the offset DAC |

## Verification
The sum and the count take in a sample at the clock edge where it is presented. A window end that is seen in the cycle after the last window sample changes `corr_o` one edge later. A register write changes `corr_o` at the edge that stores it, because the loop-off select and the target feed the output through logic only. The bench drives inputs 1 ns after each rising edge and steps a cycle model of these rules through the same edge. It compares `corr_o` against that model 2 ns after each edge, and checks hand-computed values at the same points.

// File: rtl/obc_pkg.sv
package obc_pkg;
  parameter int SMP_W  = 12;
  parameter int CORR_W = 8;
  parameter int CNT_W  = 10;
  parameter int SH_W   = 3;
  parameter int DIV_W  = 8;
  parameter int TGT_SH = 2;
  parameter logic [CORR_W-1:0] TGT_RST = 8'h40;

  localparam int ERR_W    = SMP_W + 2;
  localparam int SUM_W    = ERR_W + CNT_W;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;
  localparam int CORR_MID = 1 << (CORR_W - 1);
  localparam int CORR_TOP = (1 << CORR_W) - 1;

  typedef logic signed [ERR_W-1:0] err_t;
  typedef logic signed [SUM_W-1:0] sum_t;

  // signed distance of one sample from the scaled target
  function automatic err_t pix_err(input logic [CORR_W-1:0] tgt,
                                   input logic [SMP_W-1:0] smp);
    err_t t, s;
    t = {{(ERR_W-CORR_W-TGT_SH){1'b0}}, tgt, {TGT_SH{1'b0}}};
    s = {{(ERR_W-SMP_W){1'b0}}, smp};
    return t - s;
  endfunction

  // mean error (truncated toward zero) scaled down by the shift
  function automatic sum_t avg_step(input sum_t sum,
                                    input logic [CNT_W-1:0] n,
                                    input logic [SH_W-1:0] sh);
    sum_t d, q;
    d = {{(SUM_W-CNT_W){1'b0}}, n};
    if (n == '0) return '0;
    q = sum / d;
    return q >>> sh;
  endfunction

  // correction plus step, clamped to the DAC code range
  function automatic logic [CORR_W-1:0] sat_add(input logic [CORR_W-1:0] c,
                                                input sum_t st);
    logic signed [SUM_W:0] t;
    t = $signed({{(SUM_W+1-CORR_W){1'b0}}, c}) + $signed({st[SUM_W-1], st});
    if (t < 0) return '0;
    if (t > CORR_TOP) return '1;
    return t[CORR_W-1:0];
  endfunction
endpackage

// File: rtl/obc_regs.sv
module obc_regs
  import obc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [CORR_W-1:0] wdata,
  output logic [CORR_W-1:0] tgt,
  output logic              loop_off,
  output logic [SH_W-1:0]   sh,
  output logic [DIV_W-1:0]  div
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt      <= TGT_RST;
      loop_off <= 1'b0;
      sh       <= '0;
      div      <= '0;
    end else if (we) begin
      case (sel)
        2'd0: tgt <= wdata;
        2'd1: begin
          loop_off <= wdata[3];
          sh       <= wdata[SH_W-1:0];
        end
        2'd2: div <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/obc_win.sv
module obc_win
  import obc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             window,
  input  logic             pix_en,
  input  err_t             err,
  output sum_t             sum,
  output logic [CNT_W-1:0] cnt,
  output logic             win_start,
  output logic             win_end
);
  logic win_d;
  sum_t err_x;

  assign win_start = window & ~win_d;
  assign win_end   = ~window & win_d;
  assign err_x     = {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_d <= 1'b0;
      sum   <= '0;
      cnt   <= '0;
    end else begin
      win_d <= window;
      if (win_start) begin
        sum <= pix_en ? err_x : '0;
        cnt <= pix_en ? CNT_W'(1) : '0;
      end else if (window && pix_en && cnt != CNT_W'(CNT_MAX)) begin
        sum <= sum + err_x;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/obc_upd.sv
module obc_upd
  import obc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              win_end,
  input  logic              loop_off,
  input  logic [DIV_W-1:0]  div,
  input  logic [SH_W-1:0]   sh,
  input  sum_t              sum,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CORR_W-1:0] corr_q,
  output sum_t              step,
  output logic              upd_fire
);
  logic [DIV_W-1:0] lcnt;
  logic             line_hit;
  logic             end_live;

  assign line_hit = lcnt >= div;
  assign end_live = win_end & ~loop_off;
  assign step     = avg_step(sum, cnt, sh);
  assign upd_fire = end_live & line_hit & (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt   <= '0;
      corr_q <= CORR_W'(CORR_MID);
    end else if (end_live) begin
      if (line_hit) begin
        lcnt <= '0;
        if (cnt != '0) corr_q <= sat_add(corr_q, step);
      end else begin
        lcnt <= lcnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/obclamp_servo.sv
module obclamp_servo
  import obc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic              pix_en_i,
  input  logic              window_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CORR_W-1:0] cfg_wdata_i,
  output logic [CORR_W-1:0] corr_o
);
  logic [CORR_W-1:0] tgt;
  logic              loop_off;
  logic [SH_W-1:0]   sh;
  logic [DIV_W-1:0]  div;
  err_t              err;
  sum_t              sum;
  logic [CNT_W-1:0]  cnt;
  logic              win_start;
  logic              win_end;
  logic [CORR_W-1:0] corr_q;
  sum_t              step;
  logic              upd_fire;

  obc_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we_i), .sel(cfg_sel_i), .wdata(cfg_wdata_i),
    .tgt(tgt), .loop_off(loop_off), .sh(sh), .div(div)
  );

  assign err = pix_err(tgt, sample_i);

  obc_win u_win (
    .clk(clk), .rst(rst), .window(window_i), .pix_en(pix_en_i), .err(err),
    .sum(sum), .cnt(cnt), .win_start(win_start), .win_end(win_end)
  );

  obc_upd u_upd (
    .clk(clk), .rst(rst), .win_end(win_end), .loop_off(loop_off), .div(div),
    .sh(sh), .sum(sum), .cnt(cnt), .corr_q(corr_q), .step(step),
    .upd_fire(upd_fire)
  );

  assign corr_o = loop_off ? tgt : corr_q;
endmodule

// File: rtl/obclamp_servo_chk.sv
module obclamp_servo_chk
  import obc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              win_end,
  input logic              upd_fire,
  input logic              loop_off,
  input logic [CNT_W-1:0]  cnt,
  input logic [CORR_W-1:0] corr_q,
  input sum_t              step
);
  AST_RESET_MID: assert property (@(posedge clk)
    $past(rst) |-> corr_q == CORR_W'(CORR_MID)); // R1

  AST_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(corr_q)); // R5

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (win_end && cnt == '0) |=> $stable(corr_q)); // R6

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    loop_off |=> $stable(corr_q)); // R8

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !step[SUM_W-1]) |=> corr_q >= $past(corr_q)); // R4

  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && step[SUM_W-1]) |=> corr_q <= $past(corr_q)); // R4
endmodule

bind obclamp_servo obclamp_servo_chk u_chk (
  .clk(clk), .rst(rst), .win_end(win_end), .upd_fire(upd_fire),
  .loop_off(loop_off), .cnt(cnt), .corr_q(corr_q), .step(step)
);

// File: tb/obclamp_servo_test.sv
module obclamp_servo_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] sample_i = '0;
  logic        pix_en_i = 1'b0;
  logic        window_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  corr_o;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // cycle model state, built from the requirements
  int m_tgt, m_off, m_sh, m_div, m_corr, m_sum, m_cnt, m_wprev, m_lcnt;

  always #5 clk = ~clk;

  obclamp_servo uut (
    .clk(clk), .rst(rst), .sample_i(sample_i), .pix_en_i(pix_en_i),
    .window_i(window_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .corr_o(corr_o)
  );

  function automatic int next_corr(int c, int s, int n, int sh);
    int mean, st, r;
    mean = s / n;
    st = mean >>> sh;
    r = c + st;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  function automatic int model_out();
    return (m_off != 0) ? m_tgt : m_corr;
  endfunction

  task automatic chk(string r, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: corr_o=%0d expected=%0d at %0t", r, got, exp, $time);
    end
  endtask

  task automatic tick();
    int n_tgt = m_tgt, n_off = m_off, n_sh = m_sh, n_div = m_div;
    int n_corr = m_corr, n_sum = m_sum, n_cnt = m_cnt, n_lcnt = m_lcnt;
    int e;
    if (rst) begin
      n_tgt = 64; n_off = 0; n_sh = 0; n_div = 0;
      n_corr = 128; n_sum = 0; n_cnt = 0; n_lcnt = 0;
    end else begin
      e = m_tgt * 4 - int'(sample_i);
      if (!window_i && m_wprev != 0 && m_off == 0) begin
        if (m_lcnt >= m_div) begin
          n_lcnt = 0;
          if (m_cnt != 0) n_corr = next_corr(m_corr, m_sum, m_cnt, m_sh);
        end else n_lcnt = m_lcnt + 1;
      end
      if (window_i && m_wprev == 0) begin
        n_sum = pix_en_i ? e : 0;
        n_cnt = pix_en_i ? 1 : 0;
      end else if (window_i && pix_en_i && m_cnt < 1023) begin
        n_sum = m_sum + e;
        n_cnt = m_cnt + 1;
      end
      if (cfg_we_i) begin
        case (cfg_sel_i)
          2'd0: n_tgt = cfg_wdata_i;
          2'd1: begin n_off = cfg_wdata_i[3]; n_sh = cfg_wdata_i[2:0]; end
          2'd2: n_div = cfg_wdata_i;
          default: ;
        endcase
      end
    end
    @(posedge clk);
    m_wprev = rst ? 0 : window_i;
    m_tgt = n_tgt; m_off = n_off; m_sh = n_sh; m_div = n_div;
    m_corr = n_corr; m_sum = n_sum; m_cnt = n_cnt; m_lcnt = n_lcnt;
    #1;
    cfg_we_i = 1'b0;
    #1;
    chk(tag, int'(corr_o), model_out());
  endtask

  task automatic cyc(logic w, logic p, int s);
    window_i = w; pix_en_i = p; sample_i = 12'(s);
    tick();
  endtask

  task automatic wr(int sel, int val);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(sel); cfg_wdata_i = 8'(val);
    tick();
  endtask

  task automatic win(int n, int s);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, s);
    cyc(1'b0, 1'b0, 0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: corr_o=%0d expected=done", corr_o);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_tgt = 0; m_off = 0; m_sh = 0; m_div = 0; m_corr = 0;
    m_sum = 0; m_cnt = 0; m_wprev = 0; m_lcnt = 0;
    #1;
    tick(); tick();
    rst = 1'b0;
    cyc(1'b0, 1'b0, 0);
    chk("R1", int'(corr_o), 128);

    // R2/R3: target 0x40 -> 256, samples 250 give +6, mean 6
    tag = "R3";
    win(4, 250);
    chk("R3", int'(corr_o), 134);
    wr(1, 2);
    win(2, 200);                       // +56 >>> 2 = 14
    chk("R3", int'(corr_o), 148);
    win(3, 300);                       // -44 >>> 2 = -11
    chk("R3", int'(corr_o), 137);
    wr(1, 0);
    cyc(1'b1, 1'b1, 257);
    tag = "R5";
    chk("R5", int'(corr_o), 137);      // no change inside the window
    cyc(1'b1, 1'b1, 258);
    cyc(1'b0, 1'b0, 0);                // -3/2 truncates to -1
    chk("R2", int'(corr_o), 136);

    // R4 saturation both ways
    tag = "R4";
    wr(0, 255);
    win(2, 0);
    chk("R4", int'(corr_o), 255);
    wr(0, 0);
    win(2, 4095);
    chk("R4", int'(corr_o), 0);

    // R6 empty window
    tag = "R6";
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 4095);
    cyc(1'b0, 1'b0, 0);
    chk("R6", int'(corr_o), 0);

    // R8 loop off: target drives output, loop frozen
    tag = "R8";
    wr(0, 8'h55);
    wr(1, 8);
    chk("R8", int'(corr_o), 8'h55);
    win(4, 300);
    chk("R8", int'(corr_o), 8'h55);
    wr(1, 0);
    chk("R8", int'(corr_o), 0);

    // R7 divider 2: only third window end updates (+4 each)
    tag = "R7";
    wr(2, 2);
    win(3, 336);
    chk("R7", int'(corr_o), 0);
    win(3, 336);
    chk("R7", int'(corr_o), 0);
    win(3, 336);
    chk("R7", int'(corr_o), 4);

    // R9 select 3 has no effect
    tag = "R9";
    wr(3, 8'hFF);
    chk("R9", int'(corr_o), 4);
    wr(1, 8);
    chk("R9", int'(corr_o), 8'h55);
    wr(1, 0);
    wr(2, 0);
    win(1, 336);
    chk("R9", int'(corr_o), 8);

    // R10 count cap: 1023 samples of +4, then large negatives ignored
    tag = "R10";
    for (int i = 0; i < 1023; i++) cyc(1'b1, 1'b1, 336);
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b1, 4095);
    cyc(1'b0, 1'b0, 0);
    chk("R10", int'(corr_o), 12);

    // constrained random mix
    tag = "R2";
    void'($urandom(32'd1234));
    for (int it = 0; it < 600; it++) begin
      int len, gap, s;
      if ($urandom_range(0, 5) == 0) begin
        int sel = $urandom_range(0, 3);
        int v = (sel == 1) ? (($urandom_range(0, 9) == 0) ? 8 : 0) + $urandom_range(0, 7)
              : (sel == 2) ? $urandom_range(0, 3) : $urandom_range(0, 255);
        wr(sel, v);
      end
      if ($urandom_range(0, 49) == 0) begin
        rst = 1'b1; tick(); rst = 1'b0;
      end
      len = $urandom_range(0, 40);
      for (int i = 0; i < len; i++) begin
        s = m_tgt * 4 + $urandom_range(0, 127) - 64;
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        cyc(1'b1, ($urandom_range(0, 3) != 0), s);
      end
      gap = $urandom_range(1, 5);
      for (int i = 0; i < gap; i++) cyc(1'b0, 1'($urandom_range(0, 1)), $urandom_range(0, 4095));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule